// File: doc/BRIEF.md
# Indirect Configuration and Port Access Window

This block gives a host a small register window through which it reaches a downstream bus's configuration space and I/O-port space. The host first loads a 32-bit target address into a pointer register. It then reads or writes one of two data windows. Which window it touches fixes the cycle type: one window produces configuration cycles and the other produces I/O-port cycles. The low bits of the window offset, together with the access size, choose the byte lanes.

For every data-window access the block issues one downstream request. A request carries the cycle type, a dword-aligned address, active-high byte enables and lane-steered write data. The block holds the request until the target acknowledges it. Returned data is moved back to the host's low bits. The host access stalls, with `ready` held low, until the whole exchange is done.

Configuration writes are guarded against a bridge hazard. The block first issues a dummy configuration read to the same bus and device with the register byte cleared. Only then does it issue the write itself. The downstream side is little-endian: lane 0 is bits 7:0.

Top module: `cfg_io_window`

## Requirements
- R1: After reset `h_ready`, `h_err` and `dn_req` are low, and the pointer register reads back as zero.
- R2: The pointer register sits at offset 0x064. It is written and read with the same lane steering as the data windows: narrow writes change only their lanes, and reads are right-justified. No data-window access changes it.
- R3: An access at offset 0x068..0x06B issues a configuration cycle (`dn_io`=0). An access at 0x06C..0x06F issues an I/O-port cycle (`dn_io`=1). In both cases `dn_addr` is the pointer value with bits 1:0 cleared.
- R4: `h_size` is encoded as 0 = byte, 1 = 16-bit, 2 = 32-bit, and lane = offset bits 1:0. The byte enables are 1<<lane for a byte, 4'b0011<<(2*lane[1]) for 16-bit, and 4'hF for 32-bit.
- R5: On a write, the low bytes of `h_wdata` (as many as the size) appear on `dn_wdata` shifted left by 8*lane. Disabled lanes are zero.
- R6: On a read, `h_rdata` is `dn_rdata` shifted right by 8*lane and zero-extended above the access size.
- R7: Each configuration write is preceded by one configuration read with `dn_wr`=0, `dn_be`=4'hF and `dn_addr` = {pointer[31:8], 8'h00}. Configuration reads and all I/O-port accesses issue exactly one request.
- R8: The following accesses to a mapped offset are misaligned: a 16-bit access with lane bit 0 set, a 32-bit access with a nonzero lane, and size code 3. A misaligned access completes with `h_err`=1 and `h_rdata`=0. It issues no request and leaves the pointer unchanged.
- R9: `h_ready` rises only after the final request is acknowledged. `dn_req` and all request fields stay stable until `dn_ack`.
- R10: An access to any other offset completes without error, reads zero, issues no request and changes nothing.
- R11: `h_ready` is a single-cycle pulse per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| h_valid | input | 1 | Host access pending, held until h_ready |
| h_write | input | 1 | 1 = write, 0 = read |
| h_off | input | AW | Byte offset within the register window |
| h_size | input | 2 | 0 byte, 1 16-bit, 2 32-bit |
| h_wdata | input | 32 | Right-justified host write data |
| h_rdata | output | 32 | Right-justified host read data, valid with h_ready |
| h_ready | output | 1 | Access complete pulse |
| h_err | output | 1 | Misaligned access, valid with h_ready |
| dn_req | output | 1 | Downstream request valid |
| dn_io | output | 1 | 1 = I/O-port cycle, 0 = configuration cycle |
| dn_wr | output | 1 | 1 = write cycle |
| dn_addr | output | 32 | Dword-aligned downstream address |
| dn_be | output | 4 | Active-high byte enables |
| dn_wdata | output | 32 | Lane-steered write data |
| dn_ack | input | 1 | Downstream completion |
| dn_rdata | input | 32 | Downstream read data, valid with dn_ack |

## Verification
Two events can coincide in one cycle: the target's acknowledge and the first cycle of a request. The case that matters most is the dummy read ahead of a configuration write, because the real write must then start right behind it. The bench's target model sometimes acknowledges with zero wait and otherwise after a random delay. It logs every distinct request. The ordered log is then compared with the sequence expected for that access, including the dummy read's cleared register byte and the write's lanes.

// File: rtl/cfg_io_window.sv
module cfg_io_window #(
  parameter int AW = 12,
  parameter logic [AW-1:0] PTR_OFF = 12'h064,
  parameter logic [AW-1:0] CFG_OFF = 12'h068,
  parameter logic [AW-1:0] PIO_OFF = 12'h06C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_valid,
  input  logic          h_write,
  input  logic [AW-1:0] h_off,
  input  logic [1:0]    h_size,
  input  logic [31:0]   h_wdata,
  output logic [31:0]   h_rdata,
  output logic          h_ready,
  output logic          h_err,
  output logic          dn_req,
  output logic          dn_io,
  output logic          dn_wr,
  output logic [31:0]   dn_addr,
  output logic [3:0]    dn_be,
  output logic [31:0]   dn_wdata,
  input  logic          dn_ack,
  input  logic [31:0]   dn_rdata
);

  typedef enum logic [1:0] {S_IDLE, S_DUMMY, S_MAIN, S_RESP} st_t;
  st_t st;

  logic [31:0] ptr_q, wd_q, rd_q;
  logic [3:0]  be_q;
  logic [1:0]  lane_q, size_q;
  logic        io_q, wr_q, err_q;

  function automatic logic [3:0] lane_be(input logic [1:0] sz, input logic [1:0] ln);
    case (sz)
      2'd0:    lane_be = 4'b0001 << ln;
      2'd1:    lane_be = 4'b0011 << {ln[1], 1'b0};
      2'd2:    lane_be = 4'b1111;
      default: lane_be = 4'b0000;
    endcase
  endfunction

  function automatic logic [31:0] be_mask(input logic [3:0] be);
    be_mask = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  function automatic logic [31:0] pull(input logic [31:0] d, input logic [1:0] ln,
                                       input logic [1:0] sz);
    logic [31:0] s;
    s = d >> {ln, 3'b000};
    case (sz)
      2'd0:    pull = {24'h0, s[7:0]};
      2'd1:    pull = {16'h0, s[15:0]};
      default: pull = s;
    endcase
  endfunction

  wire [1:0]  lane   = h_off[1:0];
  wire        hit_p  = h_off[AW-1:2] == PTR_OFF[AW-1:2];
  wire        hit_c  = h_off[AW-1:2] == CFG_OFF[AW-1:2];
  wire        hit_i  = h_off[AW-1:2] == PIO_OFF[AW-1:2];
  wire        misal  = (h_size == 2'd3) || (h_size == 2'd1 && lane[0]) ||
                       (h_size == 2'd2 && lane != 2'd0);
  wire [3:0]  be_c   = lane_be(h_size, lane);
  wire [31:0] msk_c  = be_mask(be_c);
  wire [31:0] wst_c  = (h_wdata << {lane, 3'b000}) & msk_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ptr_q  <= '0;
      wd_q   <= '0;
      rd_q   <= '0;
      be_q   <= '0;
      lane_q <= '0;
      size_q <= '0;
      io_q   <= 1'b0;
      wr_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (h_valid) begin
          rd_q  <= '0;
          err_q <= 1'b0;
          st    <= S_RESP;
          if ((hit_p || hit_c || hit_i) && misal) begin
            err_q <= 1'b1;
          end else if (hit_p) begin
            if (h_write) ptr_q <= (ptr_q & ~msk_c) | wst_c;
            else         rd_q  <= pull(ptr_q, lane, h_size);
          end else if (hit_c || hit_i) begin
            io_q   <= hit_i;
            wr_q   <= h_write;
            be_q   <= be_c;
            wd_q   <= h_write ? wst_c : 32'h0;
            lane_q <= lane;
            size_q <= h_size;
            st     <= (hit_c && h_write) ? S_DUMMY : S_MAIN;
          end
        end
        S_DUMMY: if (dn_ack) st <= S_MAIN;
        S_MAIN: if (dn_ack) begin
          rd_q <= wr_q ? 32'h0 : pull(dn_rdata, lane_q, size_q);
          st   <= S_RESP;
        end
        default: begin
          st    <= S_IDLE;
          err_q <= 1'b0;
        end
      endcase
    end
  end

  assign h_ready  = st == S_RESP;
  assign h_err    = h_ready & err_q;
  assign h_rdata  = h_ready ? rd_q : 32'h0;
  assign dn_req   = (st == S_DUMMY) || (st == S_MAIN);
  assign dn_io    = (st == S_MAIN) & io_q;
  assign dn_wr    = (st == S_MAIN) & wr_q;
  assign dn_addr  = (st == S_DUMMY) ? {ptr_q[31:8], 8'h00} :
                    (st == S_MAIN)  ? {ptr_q[31:2], 2'b00} : 32'h0;
  assign dn_be    = (st == S_DUMMY) ? 4'hF : (st == S_MAIN) ? be_q : 4'h0;
  assign dn_wdata = dn_wr ? wd_q : 32'h0;

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req && !dn_ack) |=> (dn_req && $stable(dn_addr) && $stable(dn_be) &&
                            $stable(dn_wr) && $stable(dn_io) && $stable(dn_wdata)));

  assert_ready_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    h_ready |=> !h_ready);

  assert_err_noreq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    h_err |-> (h_ready && !dn_req && h_rdata == 32'h0));

  assert_be_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req |-> (dn_be == 4'h1 || dn_be == 4'h2 || dn_be == 4'h4 || dn_be == 4'h8 ||
                dn_be == 4'h3 || dn_be == 4'hC || dn_be == 4'hF));

  assert_dummy_then_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DUMMY && dn_ack) |-> (!dn_wr && !dn_io && dn_addr[7:0] == 8'h00)
      ##1 (dn_req && dn_wr && !dn_io));

  assert_ptr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req |=> $stable(ptr_q));

endmodule

// File: tb/cfg_io_window_bench.sv
`timescale 1ns/1ps
module cfg_io_window_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic h_valid = 0, h_write = 0;
  logic [11:0] h_off = 0;
  logic [1:0] h_size = 0;
  logic [31:0] h_wdata = 0, h_rdata, dn_addr, dn_wdata, dn_rdata = 0;
  logic h_ready, h_err, dn_req, dn_io, dn_wr, dn_ack = 0;
  logic [3:0] dn_be;

  always #2 clk = ~clk;

  cfg_io_window u_cfg_io_window (.*);

  int nchk = 0, nerr = 0;
  logic [31:0] lg_addr [8];
  logic [31:0] lg_wd [8];
  logic [3:0]  lg_be [8];
  logic        lg_io [8], lg_wr [8];
  int lg_n = 0;
  bit seen = 0, ack_r = 0, zero_wait = 0;
  int wc = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] tgt(input logic [31:0] a, input logic io);
    return (a * 32'h9E3779B1) ^ {31'h0, io} ^ 32'h5A00_0000;
  endfunction

  function automatic logic [3:0] f_be(input logic [1:0] sz, input logic [1:0] ln);
    if (sz == 0) return 4'b0001 << ln;
    if (sz == 1) return ln[1] ? 4'b1100 : 4'b0011;
    return 4'hF;
  endfunction

  function automatic logic [31:0] f_msk(input logic [1:0] sz);
    return sz == 0 ? 32'hFF : sz == 1 ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic bit f_mis(input logic [1:0] sz, input logic [1:0] ln);
    return sz == 3 || (sz == 1 && ln[0]) || (sz == 2 && ln != 0);
  endfunction

  always @(negedge clk) begin
    if (ack_r) begin ack_r = 0; seen = 0; end
    if (dn_req) begin
      if (!seen) begin
        seen = 1;
        if (lg_n < 8) begin
          lg_addr[lg_n] = dn_addr; lg_wd[lg_n] = dn_wdata; lg_be[lg_n] = dn_be;
          lg_io[lg_n] = dn_io; lg_wr[lg_n] = dn_wr;
        end
        lg_n++;
        wc = zero_wait ? 0 : int'($urandom % 4);
        dn_rdata = tgt(dn_addr, dn_io);
      end else begin
        if (lg_n >= 1 && lg_n <= 8)
          chk(dn_addr == lg_addr[lg_n-1] && dn_be == lg_be[lg_n-1] &&
              dn_wr == lg_wr[lg_n-1] && dn_wdata == lg_wd[lg_n-1], "R9",
              "request changed before ack", dn_addr, lg_addr[lg_n-1]);
        if (wc != 0) wc--;
      end
      if (wc == 0) ack_r = 1;
    end
    dn_ack = ack_r;
  end

  logic [31:0] ptr_m = 0;

  task automatic acc(input bit wr, input logic [11:0] off, input logic [1:0] sz,
                     input logic [31:0] wd, output logic [31:0] rd, output bit er);
    int cyc = 0;
    @(negedge clk);
    h_valid = 1; h_write = wr; h_off = off; h_size = sz; h_wdata = wd; lg_n = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (h_ready) break;
      if (cyc > 100) begin
        chk(0, "R9", "access hung", 0, 0);
        break;
      end
    end
    rd = h_rdata; er = h_err;
    h_valid = 0;
    @(negedge clk);
    chk(!h_ready, "R11", "ready not a single pulse", {31'h0, h_ready}, 0);
  endtask

  task automatic run(input bit wr, input logic [11:0] off, input logic [1:0] sz,
                     input logic [31:0] wd);
    logic [31:0] rd, a, m, ex, wst;
    bit er, mapped, win, io, mis;
    logic [1:0] ln;
    int base;
    ln = off[1:0];
    mapped = off[11:2] == 10'h019 || off[11:2] == 10'h01A || off[11:2] == 10'h01B;
    win = off[11:2] == 10'h01A || off[11:2] == 10'h01B;
    io = off[11:2] == 10'h01B;
    mis = mapped && f_mis(sz, ln);
    m = {{8{f_be(sz, ln)[3]}}, {8{f_be(sz, ln)[2]}}, {8{f_be(sz, ln)[1]}}, {8{f_be(sz, ln)[0]}}};
    wst = (wd << (8 * ln)) & m;
    acc(wr, off, sz, wd, rd, er);
    chk(er == mis, "R8", "error flag", {31'h0, er}, {31'h0, mis});
    if (mis || !win) begin
      chk(lg_n == 0, mis ? "R8" : "R10", "unexpected request", lg_n, 0);
      if (mis || !mapped) chk(rd == 0, mis ? "R8" : "R10", "read data", rd, 0);
      if (!mis && mapped) begin
        if (wr) ptr_m = (ptr_m & ~m) | wst;
        else chk(rd == ((ptr_m >> (8 * ln)) & f_msk(sz)), "R2", "pointer read", rd,
                 (ptr_m >> (8 * ln)) & f_msk(sz));
      end
      return;
    end
    a = {ptr_m[31:2], 2'b00};
    base = (wr && !io) ? 1 : 0;
    chk(lg_n == base + 1, "R7", "request count", lg_n, base + 1);
    if (lg_n != base + 1) return;
    if (base == 1)
      chk(!lg_wr[0] && !lg_io[0] && lg_be[0] == 4'hF && lg_addr[0] == {ptr_m[31:8], 8'h00},
          "R7", "dummy read", lg_addr[0], {ptr_m[31:8], 8'h00});
    chk(lg_io[base] == io && lg_addr[base] == a, "R3", "cycle type/address",
        lg_addr[base], a);
    chk(lg_wr[base] == wr, "R3", "direction", {31'h0, lg_wr[base]}, {31'h0, wr});
    chk(lg_be[base] == f_be(sz, ln), "R4", "byte enables", lg_be[base], f_be(sz, ln));
    if (wr) chk(lg_wd[base] == wst, "R5", "write lanes", lg_wd[base], wst);
    else begin
      ex = (tgt(a, io) >> (8 * ln)) & f_msk(sz);
      chk(rd == ex, "R6", "read data", rd, ex);
    end
  endtask

  initial begin
    #400000;
    chk(0, "R9", "watchdog expired", 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    bit er;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(!h_ready && !dn_req && !h_err, "R1", "outputs in reset",
        {29'h0, h_ready, dn_req, h_err}, 0);
    rst_n = 1;
    acc(0, 12'h064, 2, 0, rd, er);
    chk(rd == 0 && !er, "R1", "pointer after reset", rd, 0);

    run(1, 12'h064, 2, 32'h0012_3A47);
    zero_wait = 1;
    run(1, 12'h068, 2, 32'hCAFE_F00D);
    run(1, 12'h06B, 0, 32'hFFFF_FF5A);
    run(0, 12'h06E, 1, 0);
    zero_wait = 0;
    run(1, 12'h069, 1, 32'h1234);
    run(0, 12'h06D, 2, 0);
    run(0, 12'h068, 3, 0);
    run(1, 12'h200, 2, 32'hDEAD_BEEF);
    run(0, 12'h200, 2, 0);
    run(1, 12'h065, 0, 32'h77);
    run(0, 12'h064, 2, 0);
    run(1, 12'h06C, 2, 32'h0BAD_0BAD);
    run(0, 12'h064, 2, 0);

    for (int i = 0; i < 400; i++) begin
      int r;
      logic [11:0] off;
      r = int'($urandom % 8);
      zero_wait = ($urandom % 3) == 0;
      off = r < 2 ? 12'h064 : r < 5 ? 12'h068 : r < 7 ? 12'h06C : 12'h100 + 12'($urandom % 64);
      off[1:0] = 2'($urandom % 4);
      run(($urandom % 2) == 1, off, ($urandom % 8) == 0 ? 2'd3 : 2'($urandom % 3), $urandom);
    end
    run(0, 12'h064, 2, 0);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule